// File: doc/BRIEF.md
# Time Base and Watchdog Generator

This block turns a single-cycle source enable into a periodic time-base square wave and a watchdog time-out flag. It then routes one of the two to an active-low interrupt pin. The pin is modelled as two signals: a pull-low request and an output-enable. When the enable is low, the pin is released and floats. Everything runs on one synchronous clock. The selected oscillator appears only as the `src_tick` pulse, which arrives either at 256 kHz or at 32.768 kHz.

A divider chain is shared by the time base and the watchdog. It has three parts: a divide-by-8 prescaler that is used only for the 256 kHz sources, a time-base counter, and a 2-bit period counter for the watchdog. Single-cycle strobes from an external command decoder configure the block. These strobes cover the clock source, the output frequency, the timer and watchdog enables, the clear operations, the interrupt enable and system power.

Top module: `tbwd_gen`

## Requirements
- R1: After reset, `irq_oe` and `irq_low` are 0. The reset state is as follows: source is RC (`src_sel`=2'b10), frequency code is 7, the time base is stopped, nothing is routed and the system is off.
- R2: The source is written by `src_wr` with the following encoding of `src_sel`: 2'b01 selects the crystal, 2'b10 the RC source and 2'b11 the external source; 2'b00 is ignored. For the RC and external sources, one divider tick happens every 8 `src_tick` pulses. For the crystal source, every pulse is a divider tick.
- R3: `freq_wr` loads `freq_sel` (0 to 7). The time base is a 50% square wave with a period of 2^(TB_W+7-code) divider ticks. Code 7 is the fastest rate and is the reset default.
- R4: With the watchdog routed, the flag sets exactly four time-base periods after a clear-watchdog.
- R5: Once set, the watchdog flag stays set until `clr_wdt` clears it. While the flag is set and routed, `irq_low` is held at 1.
- R6: `irq_dis` releases the pin: `irq_oe` and `irq_low` both go to 0. It does not clear the watchdog flag, so a later `irq_en` with the watchdog routed shows the pin low again.
- R7: `tmr_en` starts the time base and routes it to the pin, with `irq_low` high during the high half of the wave. `wdt_en` starts the time base and routes the flag. `tmr_dis` removes the timer routing and leaves `irq_low` at 0.
- R8: `wdt_dis` stops the whole divider chain, which freezes the timer output, and removes the watchdog routing.
- R9: `clr_tmr` clears the prescaler and the time-base counter but keeps the watchdog period count. `clr_wdt` clears the prescaler, the counter, the period count and the flag.
- R10: `sys_en` enables counting. `sys_dis` stops counting when the crystal or RC source is selected. With the external source selected, `sys_dis` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 1 | Single-cycle enable at the selected source rate |
| src_wr | input | 1 | Strobe: load clock source |
| src_sel | input | 2 | Clock source code (see R2) |
| freq_wr | input | 1 | Strobe: load frequency code |
| freq_sel | input | 3 | Frequency code (see R3) |
| tmr_en | input | 1 | Strobe: start time base, route it to pin |
| tmr_dis | input | 1 | Strobe: remove timer routing |
| wdt_en | input | 1 | Strobe: start time base, route watchdog flag |
| wdt_dis | input | 1 | Strobe: stop divider chain, remove watchdog routing |
| clr_tmr | input | 1 | Strobe: clear time-base counter |
| clr_wdt | input | 1 | Strobe: clear counter, watchdog stages and flag |
| irq_en | input | 1 | Strobe: drive interrupt pin |
| irq_dis | input | 1 | Strobe: release interrupt pin |
| sys_en | input | 1 | Strobe: system on |
| sys_dis | input | 1 | Strobe: system off (ignored for external source) |
| irq_low | output | 1 | Pull the interrupt pin low |
| irq_oe | output | 1 | Interrupt pin driven; 0 means floating |

## Verification
The bench measures the period and the high time for every frequency code under all three sources. A wrong stage tap or a missing prescaler would show up as a period that is off by a power of two. It also measures the watchdog delay from a clear to the flag. An off-by-one in the 2-bit period counter would fire after three or five periods. Clear-timer is issued in the fourth period to show that the period count survives; a design that also reset the watchdog stages would then need four more periods instead of one. Further directed cases freeze the chain with watchdog-disable and with system-disable, and check that system-disable is ignored under the external source. They also release and re-enable the pin while the flag is latched, where a design that cleared the flag on release would leave the pin high.

// File: rtl/tbwd_gen.sv
module tbwd_gen #(
  parameter int TB_W  = 8,
  parameter int PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       src_wr,
  input  logic [1:0] src_sel,
  input  logic       freq_wr,
  input  logic [2:0] freq_sel,
  input  logic       tmr_en,
  input  logic       tmr_dis,
  input  logic       wdt_en,
  input  logic       wdt_dis,
  input  logic       clr_tmr,
  input  logic       clr_wdt,
  input  logic       irq_en,
  input  logic       irq_dis,
  input  logic       sys_en,
  input  logic       sys_dis,
  output logic       irq_low,
  output logic       irq_oe
);
  localparam int CNT_W = TB_W + 7;
  localparam logic [1:0] SRC_XTAL = 2'b01, SRC_RC = 2'b10, SRC_EXT = 2'b11;
  localparam logic [1:0] RT_NONE = 2'd0, RT_TMR = 2'd1, RT_WDT = 2'd2;

  logic [1:0]       src_q, route_q, wcnt_q;
  logic [2:0]       freq_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, tap_now, tap_nxt;
  logic             run_q, sys_q, irq_q, flag_q;
  logic             active, base_tick, period_end, tb_bit;

  assign active     = run_q && (sys_q || src_q == SRC_EXT);
  assign base_tick  = active && src_tick && (src_q == SRC_XTAL || &pre_q);
  assign cnt_nxt    = cnt_q + 1'b1;
  assign tap_now    = cnt_q >> (3'd7 - freq_q);
  assign tap_nxt    = cnt_nxt >> (3'd7 - freq_q);
  assign tb_bit     = tap_now[TB_W-1];
  assign period_end = base_tick && tb_bit && !tap_nxt[TB_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_RC;
      freq_q <= 3'd7;
      sys_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (src_wr && src_sel != 2'b00) src_q <= src_sel;
      if (freq_wr) freq_q <= freq_sel;
      if (sys_en) sys_q <= 1'b1;
      else if (sys_dis && src_q != SRC_EXT) sys_q <= 1'b0;
      if (irq_en) irq_q <= 1'b1;
      else if (irq_dis) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      route_q <= RT_NONE;
    end else if (tmr_en) begin
      run_q   <= 1'b1;
      route_q <= RT_TMR;
    end else if (wdt_en) begin
      run_q   <= 1'b1;
      route_q <= RT_WDT;
    end else if (wdt_dis) begin
      run_q <= 1'b0;
      if (route_q == RT_WDT) route_q <= RT_NONE;
    end else if (tmr_dis && route_q == RT_TMR) begin
      route_q <= RT_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      flag_q <= 1'b0;
    end else if (clr_wdt) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      flag_q <= 1'b0;
    end else if (clr_tmr) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (active && src_tick && src_q != SRC_XTAL) pre_q <= pre_q + 1'b1;
      if (base_tick) cnt_q <= cnt_nxt;
      if (period_end && route_q == RT_WDT) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (wcnt_q == 2'd3) flag_q <= 1'b1;
      end
    end
  end

  assign irq_oe  = irq_q;
  assign irq_low = irq_q && ((route_q == RT_TMR && tb_bit) || (route_q == RT_WDT && flag_q));

  // R4
  wdt_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wcnt_q) == 2'd3);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wdt |=> flag_q);

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !clr_tmr && !clr_wdt |=> $stable(cnt_q));

  // R10
  ext_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_q == SRC_EXT && active && sys_dis && !wdt_dis && !src_wr |=> active);
endmodule

// File: tb/tbwd_gen_tb.sv
module tbwd_gen_tb;
  localparam int CLK_NS = 10;
  localparam int TBW    = 2;

  logic clk = 0, rst_n = 0, src_tick = 1;
  logic src_wr = 0, freq_wr = 0, tmr_en = 0, tmr_dis = 0, wdt_en = 0, wdt_dis = 0;
  logic clr_tmr = 0, clr_wdt = 0, irq_en = 0, irq_dis = 0, sys_en = 0, sys_dis = 0;
  logic [1:0] src_sel = 0;
  logic [2:0] freq_sel = 0;
  logic irq_low, irq_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  tbwd_gen #(.TB_W(TBW)) u_dut (
    .clk, .rst_n, .src_tick, .src_wr, .src_sel, .freq_wr, .freq_sel,
    .tmr_en, .tmr_dis, .wdt_en, .wdt_dis, .clr_tmr, .clr_wdt,
    .irq_en, .irq_dis, .sys_en, .sys_dis, .irq_low, .irq_oe);

  function automatic int exp_per(input int src, input int code);
    return (1 << (TBW + 7 - code)) * ((src == 1) ? 1 : 8);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // command codes: 0 src,1 freq,2 tmr_en,3 tmr_dis,4 wdt_en,5 wdt_dis,6 clr_tmr,
  // 7 clr_wdt,8 irq_en,9 irq_dis,10 sys_en,11 sys_dis
  task automatic cmd(input int c, input int arg = 0);
    @(negedge clk);
    case (c)
      0: begin src_wr = 1; src_sel = 2'(arg); end
      1: begin freq_wr = 1; freq_sel = 3'(arg); end
      2: tmr_en = 1;   3: tmr_dis = 1;  4: wdt_en = 1;  5: wdt_dis = 1;
      6: clr_tmr = 1;  7: clr_wdt = 1;  8: irq_en = 1;  9: irq_dis = 1;
      10: sys_en = 1;  11: sys_dis = 1;
      default: ;
    endcase
    @(negedge clk);
    {src_wr, freq_wr, tmr_en, tmr_dis, wdt_en, wdt_dis} = '0;
    {clr_tmr, clr_wdt, irq_en, irq_dis, sys_en, sys_dis} = '0;
  endtask

  task automatic meas(output int hi, output int per);
    int n = 0;
    logic prev = irq_low;
    hi = -1; per = -1;
    do begin prev = irq_low; @(negedge clk); n++; end
    while (!(prev == 0 && irq_low == 1) && n < 40000);
    if (n >= 40000) return;
    n = 0;
    do begin @(negedge clk); n++; end while (irq_low && n < 40000);
    hi = n;
    do begin @(negedge clk); n++; end while (!irq_low && n < 40000);
    per = n;
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (!irq_low && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic stable_for(input string req, input int cyc);
    logic ref_v = irq_low;
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (irq_low != ref_v) bad++; end
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, per, n, src, code;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 irq_oe", irq_oe, 0);
    chk("R1 irq_low", irq_low, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {irq_oe, irq_low}, 0);

    // R3 default code 7 with default RC source; R10 sys_en required
    cmd(2); cmd(8); stable_for("R10 off at reset", 80);
    cmd(10); cmd(6);
    meas(hi, per);
    chk("R3 default period", per, exp_per(2, 7));
    chk("R3 default high", hi, exp_per(2, 7) / 2);

    // R2 R3 random sources and codes
    for (int k = 0; k < 8; k++) begin
      src = 1 + int'($urandom_range(2, 0));
      code = (k < 2) ? k * 7 : int'($urandom_range(7, 0));
      cmd(0, src); cmd(1, code); cmd(6);
      meas(hi, per);
      chk("R2 R3 period", per, exp_per(src, code));
      chk("R3 duty", hi, exp_per(src, code) / 2);
    end

    // R7 tmr_dis removes routing
    cmd(0, 1); cmd(1, 6);
    cmd(3); chk("R7 tmr_dis low", irq_low, 0);
    stable_for("R7 tmr_dis quiet", 2 * exp_per(1, 6));

    // R4 watchdog after four periods
    for (int k = 0; k < 4; k++) begin
      src = (k % 2) ? 2 : 1;
      code = int'($urandom_range(7, 2));
      cmd(0, src); cmd(1, code); cmd(4); cmd(7);
      wait_low(n);
      chk("R4 wdt delay", n, 4 * exp_per(src, code));
    end

    // R5 latch
    stable_for("R5 flag holds", 300);
    chk("R5 still low", irq_low, 1);

    // R6 release keeps flag
    cmd(9); chk("R6 oe off", irq_oe, 0); chk("R6 low off", irq_low, 0);
    cmd(8); chk("R6 flag kept", irq_low, 1);

    // R7 routing swaps
    cmd(0, 1); cmd(1, 5); cmd(2);
    meas(hi, per); chk("R7 timer route period", per, exp_per(1, 5));
    cmd(4); chk("R7 wdt route flag shown", irq_low, 1);
    cmd(7); chk("R5 clr_wdt releases", irq_low, 0);

    // R9 clr_tmr keeps watchdog count
    cmd(1, 4); cmd(7);
    repeat (3 * exp_per(1, 4) + 3) @(negedge clk);
    chk("R9 no flag yet", irq_low, 0);
    cmd(6); wait_low(n);
    chk("R9 one period left", n, exp_per(1, 4));

    // R8 wdt_dis freezes chain and drops wdt routing
    cmd(8); chk("R8 pre", irq_low, 1);
    cmd(5); chk("R8 wdt route removed", irq_low, 0);
    cmd(2); cmd(1, 3); repeat (exp_per(1, 3) / 4 + 1) @(negedge clk);
    cmd(5); stable_for("R8 frozen", 2 * exp_per(1, 3));
    cmd(2); cmd(6); meas(hi, per); chk("R8 resumes", per, exp_per(1, 3));

    // R10 sys_dis with RC stops, with EXT ignored
    cmd(0, 2); cmd(1, 6); cmd(11);
    stable_for("R10 rc sys_dis frozen", 2 * exp_per(2, 6));
    cmd(10); cmd(6); meas(hi, per); chk("R10 sys_en resumes", per, exp_per(2, 6));
    cmd(0, 3); cmd(11); cmd(6);
    meas(hi, per); chk("R10 ext ignores sys_dis", per, exp_per(3, 6));
    cmd(0, 0); cmd(6);
    meas(hi, per); chk("R2 code 00 ignored", per, exp_per(3, 6));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule